// File: doc/BRIEF.md
# Prescaled Four-Channel Compare Timer

This block is a bus-mapped timer. A free-running counter advances once per prescaled period of the peripheral clock, and a set of compare channels watch it. Each compare channel owns a compare value and a 3-bit action field. When the counter steps onto a compare value, the channel can raise a sticky interrupt flag, schedule the counter to return to zero, or halt counting. A single level interrupt output reflects the OR of the flags.

Software drives it through a simple word-addressed register bus. It writes the prescale value, the compare values and the action fields, and then sets the run bit. It services interrupts by reading the flag register and writing ones back to clear the flags. Because the counter keeps its value exactly while halted, a driver can halt it, read it, program a compare value relative to that reading and restart it without losing time.

Byte offsets used by the bus: flags 0x00, control 0x04, counter 0x08, prescale 0x0C, prescale counter 0x10, action fields 0x14, compare values from 0x18 in steps of 4 (channel i at 0x18+4*i), count mode 0x70. Control bit 0 is run and bit 1 is hold-in-reset. Channel i's action field sits at bits 3*i+2..3*i: bit +0 interrupt, bit +1 restart, bit +2 halt. Flag bit i belongs to channel i.

Top module: `match_timer`

## Requirements
- R1: With control bit 0 cleared, the counter and prescale counter keep their exact value from cycle to cycle; setting bit 0 resumes counting from that value.
- R2: While control bit 1 is set, the counter and the prescale counter read 0 and no compare event occurs.
- R3: With prescale value N, the counter advances by one every N+1 clock cycles while running, and the prescale counter (offset 0x10) counts 0..N.
- R4: A compare event happens only on the counter step that lands on the compare value; a compare value equal to the current, unchanging count gives no event, and neither do direct counter writes or the step back to zero after a restart.
- R5: On a compare event with action bit +0 set, flag bit i (offset 0x00) becomes 1.
- R6: Writing flags clears every bit written as 1 and leaves bits written as 0; a flag being set in the same cycle as its clear stays set.
- R7: With action bit +1 set, the counter steps from the compare value to 0 on the next prescaled step, so the cycle covers compare value + 1 counts.
- R8: With action bit +2 set, a compare event clears control bit 0 and the counter remains at the compare value.
- R9: The interrupt output is high exactly when at least one flag bit is set, changing on the same clock edge as the flags.
- R10: The counter wraps from all ones to 0, and a compare value reached by the wrap produces an event.
- R11: The counter advances only when the count-mode register (offset 0x70) holds 0; any other value halts it.
- R12: After synchronous reset every register reads 0; read data appears on the cycle after the read request; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt, OR of all flags |

## Verification
The bench builds the block with its defaults: a 32-bit counter, a 32-bit prescaler and four channels, so every action field and every flag bit is driven. Writing the counter just below all ones puts the wrap and an event reached through it within a few cycles. Prescale values of 0, 1 and 3 exercise both the single-cycle step, where restart and compare land on adjacent cycles, and the multi-cycle step, where the restart waits for the next prescaled step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Byte offsets on the register bus
  localparam int OFS_FLAG  = 'h00;
  localparam int OFS_CTRL  = 'h04;
  localparam int OFS_TC    = 'h08;
  localparam int OFS_PR    = 'h0C;
  localparam int OFS_PC    = 'h10;
  localparam int OFS_MCR   = 'h14;
  localparam int OFS_MR0   = 'h18;
  localparam int OFS_MODE  = 'h70;

  // Control register bits
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;

  // Per-channel action field
  localparam int ACT_W     = 3;
  localparam int ACT_IRQ   = 0;
  localparam int ACT_RST   = 1;
  localparam int ACT_STOP  = 2;

  localparam int MODE_W    = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [PRE_W-1:0] limit_i,
  input  logic             wr_i,
  input  logic [PRE_W-1:0] wdata_i,
  output logic [PRE_W-1:0] pc_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q;

  assign tick_o = run_i && (pc_q == limit_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i)  pc_q <= '0;
    else if (wr_i)      pc_q <= wdata_i;
    else if (tick_o)    pc_q <= '0;
    else if (run_i)     pc_q <= pc_q + 1'b1;
  end

  // R3
  pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !wr_i) |=> (pc_q == '0));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (pc_q == '0));
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic             step_i,
  input  logic             block_i,
  output logic [CNT_W-1:0] mr_o,
  output logic             hit_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] mr_q;
  logic             pend_q;

  // Event only when the step lands on the compare value
  assign hit_o  = step_i && !block_i && ((tc_i + 1'b1) == mr_q);
  assign mr_o   = mr_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst)       mr_q <= '0;
    else if (wr_i) mr_q <= wdata_i;
  end

  // A restart request is consumed by the next counter step
  always_ff @(posedge clk) begin
    if (rst || hold_i) pend_q <= 1'b0;
    else if (step_i)   pend_q <= hit_o && rst_en_i;
  end

  // R7
  pend_from_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && $rose(pend_q)) |-> $past(step_i && rst_en_i));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32,
  parameter int NUM_CH = 4,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int MCR_W = NUM_CH * ACT_W;

  logic               run_q, hold_q;
  logic [MODE_W-1:0]  mode_q;
  logic [PRE_W-1:0]   pr_q, pc_q;
  logic [CNT_W-1:0]   tc_q;
  logic [MCR_W-1:0]   mcr_q;
  logic [NUM_CH-1:0]  flag_q, flag_d;
  logic               irq_q;
  logic [DW-1:0]      rdata_q, rd_mux;

  logic [CNT_W-1:0]   mr_q [NUM_CH];
  logic [NUM_CH-1:0]  hit, pend, set_vec, stop_vec, wr_mr;
  logic               tick, step, cnt_run, pend_any, stop_any;

  logic wr_any, wr_flag, wr_ctrl, wr_tc, wr_pr, wr_pc, wr_mcr, wr_mode, rd_req;

  assign wr_any  = bus_sel && bus_wr;
  assign rd_req  = bus_sel && !bus_wr;
  assign wr_flag = wr_any && (bus_addr == AW'(OFS_FLAG));
  assign wr_ctrl = wr_any && (bus_addr == AW'(OFS_CTRL));
  assign wr_tc   = wr_any && (bus_addr == AW'(OFS_TC));
  assign wr_pr   = wr_any && (bus_addr == AW'(OFS_PR));
  assign wr_pc   = wr_any && (bus_addr == AW'(OFS_PC));
  assign wr_mcr  = wr_any && (bus_addr == AW'(OFS_MCR));
  assign wr_mode = wr_any && (bus_addr == AW'(OFS_MODE));

  assign cnt_run  = run_q && !hold_q && (mode_q == '0);
  assign step     = tick && !wr_tc;
  assign pend_any = |pend;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run_i   (cnt_run),
    .hold_i  (hold_q),
    .limit_i (pr_q),
    .wr_i    (wr_pc),
    .wdata_i (bus_wdata[PRE_W-1:0]),
    .pc_o    (pc_q),
    .tick_o  (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_mr[g] = wr_any && (bus_addr == AW'(OFS_MR0 + 4 * g));

    tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .hold_i   (hold_q),
      .wr_i     (wr_mr[g]),
      .wdata_i  (bus_wdata[CNT_W-1:0]),
      .rst_en_i (mcr_q[g*ACT_W + ACT_RST]),
      .tc_i     (tc_q),
      .step_i   (step),
      .block_i  (pend_any),
      .mr_o     (mr_q[g]),
      .hit_o    (hit[g]),
      .pend_o   (pend[g])
    );

    assign set_vec[g]  = hit[g] && mcr_q[g*ACT_W + ACT_IRQ];
    assign stop_vec[g] = hit[g] && mcr_q[g*ACT_W + ACT_STOP];
  end

  assign stop_any = |stop_vec;

  // Counter
  always_ff @(posedge clk) begin
    if (rst || hold_q) tc_q <= '0;
    else if (wr_tc)    tc_q <= bus_wdata[CNT_W-1:0];
    else if (step)     tc_q <= pend_any ? '0 : tc_q + 1'b1;
  end

  // Control and configuration registers; a halt event wins over a write
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      mode_q <= '0;
      pr_q   <= '0;
      mcr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[CTRL_RUN];
        hold_q <= bus_wdata[CTRL_HOLD];
      end
      if (stop_any) run_q <= 1'b0;
      if (wr_mode)  mode_q <= bus_wdata[MODE_W-1:0];
      if (wr_pr)    pr_q   <= bus_wdata[PRE_W-1:0];
      if (wr_mcr)   mcr_q  <= bus_wdata[MCR_W-1:0];
    end
  end

  // Flags: write-one-to-clear, a new event wins
  assign flag_d = (flag_q & ~(wr_flag ? bus_wdata[NUM_CH-1:0] : '0)) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |flag_d;
    end
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_FLAG): rd_mux = DW'(flag_q);
      AW'(OFS_CTRL): rd_mux = DW'({hold_q, run_q});
      AW'(OFS_TC):   rd_mux = DW'(tc_q);
      AW'(OFS_PR):   rd_mux = DW'(pr_q);
      AW'(OFS_PC):   rd_mux = DW'(pc_q);
      AW'(OFS_MCR):  rd_mux = DW'(mcr_q);
      AW'(OFS_MODE): rd_mux = DW'(mode_q);
      default:       rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == AW'(OFS_MR0 + 4 * i)) rd_mux = DW'(mr_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R1
  tc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_run && !wr_tc && !hold_q) |=> (tc_q == $past(tc_q)));

  // R2
  tc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (tc_q == '0));

  // R4
  match_land_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> (tc_q == $past(tc_q) + 1'b1));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_flag |=> ((flag_q & $past(bus_wdata[NUM_CH-1:0] & ~set_vec)) == '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (step && pend_any) |=> (tc_q == '0));

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    stop_any |=> !run_q);

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flag_q));
endmodule

// File: tb/tb_match_timer.sv
`timescale 1ns/1ps
module tb_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #2.5 clk = ~clk;

  match_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R12";

  // ---------------- behavioural reference ----------------
  bit          m_run, m_hold, m_irq;
  int          m_mode;
  logic [31:0] m_pr, m_pc, m_tc, m_mcr, m_flags, m_pend, m_rdata;
  logic [31:0] m_mr [4];

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    case (a)
      8'h00: return m_flags;
      8'h04: return {30'd0, m_hold, m_run};
      8'h08: return m_tc;
      8'h0C: return m_pr;
      8'h10: return m_pc;
      8'h14: return m_mcr;
      8'h18: return m_mr[0];
      8'h1C: return m_mr[1];
      8'h20: return m_mr[2];
      8'h24: return m_mr[3];
      8'h70: return 32'(m_mode);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_hold = 0; m_irq = 0; m_mode = 0;
      m_pr = 0; m_pc = 0; m_tc = 0; m_mcr = 0; m_flags = 0; m_pend = 0; m_rdata = 0;
      foreach (m_mr[k]) m_mr[k] = 0;
    end else begin
      bit w, running, tick, wtc, anyp, halt;
      logic [31:0] ev, nflags;
      w       = bus_sel && bus_wr;
      wtc     = w && bus_addr == 8'h08;
      running = m_run && !m_hold && m_mode == 0;
      tick    = running && (m_pc == m_pr);
      anyp    = m_pend != 0;
      ev      = 0;
      halt    = 0;
      for (int i = 0; i < 4; i++)
        if (tick && !wtc && !anyp && (m_tc + 32'd1) == m_mr[i]) ev[i] = 1;
      if (bus_sel && !bus_wr) m_rdata = ref_read(bus_addr);
      nflags = m_flags;
      if (w && bus_addr == 8'h00) nflags = nflags & ~{28'd0, bus_wdata[3:0]};
      for (int i = 0; i < 4; i++) begin
        if (ev[i] && m_mcr[3*i])   nflags[i] = 1;
        if (ev[i] && m_mcr[3*i+2]) halt = 1;
      end
      // counter
      if (m_hold)            m_tc = 0;
      else if (wtc)          m_tc = bus_wdata;
      else if (tick)         m_tc = anyp ? 32'd0 : m_tc + 32'd1;
      // pending restarts
      if (m_hold) m_pend = 0;
      else if (tick && !wtc) begin
        m_pend = 0;
        for (int i = 0; i < 4; i++) if (ev[i] && m_mcr[3*i+1]) m_pend[i] = 1;
      end
      // prescale counter
      if (m_hold)                          m_pc = 0;
      else if (w && bus_addr == 8'h10)     m_pc = bus_wdata;
      else if (tick)                       m_pc = 0;
      else if (running)                    m_pc = m_pc + 1;
      // registers
      if (w && bus_addr == 8'h04) begin m_run = bus_wdata[0]; m_hold = bus_wdata[1]; end
      if (halt) m_run = 0;
      if (w && bus_addr == 8'h0C) m_pr = bus_wdata;
      if (w && bus_addr == 8'h14) m_mcr = {20'd0, bus_wdata[11:0]};
      if (w && bus_addr == 8'h70) m_mode = int'(bus_wdata[1:0]);
      for (int i = 0; i < 4; i++)
        if (w && bus_addr == 8'(8'h18 + 4*i)) m_mr[i] = bus_wdata;
      m_flags = nflags & 32'hF;
      m_irq   = m_flags != 0;
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (bus_rdata !== m_rdata || irq_o !== m_irq) begin
        errors++;
        $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, bus_rdata, irq_o, m_rdata, m_irq);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 0;

    // R12: reset values and unmapped read
    cur_req = "R12";
    rd(8'h04, v); check("R12 ctrl reset", v, 0);
    rd(8'h08, v); check("R12 counter reset", v, 0);
    rd(8'h00, v); check("R12 flags reset", v, 0);
    rd(8'h44, v); check("R12 unmapped", v, 0);

    // R3 R5 R9: prescale 3, channel 0 interrupt at 5
    cur_req = "R3";
    wr(8'h0C, 3); wr(8'h18, 5); wr(8'h14, 32'h001); wr(8'h04, 1);
    idle(12);
    rd(8'h0C, v); check("R3 prescale readback", v, 3);
    cur_req = "R5";
    idle(20);
    rd(8'h00, v); check("R5 flag ch0 set", v, 1);
    cur_req = "R9";
    check("R9 irq high", 32'(irq_o), 1);

    // R6: write zero keeps, write one clears
    cur_req = "R6";
    wr(8'h00, 0); rd(8'h00, v); check("R6 zero write keeps", v, 1);
    wr(8'h00, 1); rd(8'h00, v); check("R6 one write clears", v, 0);
    check("R9 irq low", 32'(irq_o), 0);

    // R1: halt holds the counter
    cur_req = "R1";
    wr(8'h04, 0); rd(8'h08, v); idle(10); rd(8'h08, v2);
    check("R1 counter held", v2, v);
    wr(8'h04, 1); idle(10);
    rd(8'h08, v2); checks++;
    if (!(v2 > v)) begin errors++; $display("FAIL R1: actual=%h expected>%h", v2, v); end

    // R2: hold-in-reset
    cur_req = "R2";
    wr(8'h04, 3); idle(5);
    rd(8'h08, v); check("R2 counter zero", v, 0);
    rd(8'h10, v); check("R2 prescale counter zero", v, 0);

    // R7: restart on channel 1 at 4, prescale 0
    cur_req = "R7";
    wr(8'h14, 32'h3 << 3); wr(8'h1C, 4); wr(8'h0C, 0); wr(8'h00, 32'hF);
    wr(8'h04, 1);
    for (int i = 0; i < 6; i++) begin
      rd(8'h08, v); checks++;
      if (v > 4) begin errors++; $display("FAIL R7: actual=%h expected<=4", v); end
    end
    rd(8'h00, v); check("R7 flag ch1", v, 2);

    // R8: halt on channel 2 at 20, prescale 1
    cur_req = "R8";
    wr(8'h04, 2); wr(8'h14, 32'h5 << 6); wr(8'h20, 20); wr(8'h0C, 1);
    wr(8'h00, 32'hF); wr(8'h04, 1);
    idle(60);
    rd(8'h04, v); check("R8 run cleared", v, 0);
    rd(8'h08, v); check("R8 counter at compare", v, 20);

    // R4: compare value equal to static count gives no event
    cur_req = "R4";
    wr(8'h00, 32'hF); wr(8'h0C, 0);
    wr(8'h14, 32'h1 << 9); wr(8'h24, 20); wr(8'h04, 1);
    idle(30);
    rd(8'h00, v); check("R4 no event on static equality", v, 0);

    // R10: wrap, event at 1 after wrap on channel 0
    cur_req = "R10";
    wr(8'h04, 0); wr(8'h08, 32'hFFFF_FFFD); wr(8'h18, 1);
    wr(8'h14, 32'h1); wr(8'h04, 1);
    idle(6);
    rd(8'h08, v); checks++;
    if (v > 10) begin errors++; $display("FAIL R10: actual=%h expected<=a", v); end
    rd(8'h00, v); check("R10 event after wrap", v, 1);

    // R11: nonzero count mode halts
    cur_req = "R11";
    wr(8'h70, 1); rd(8'h08, v); idle(8); rd(8'h08, v2);
    check("R11 counter frozen", v2, v);
    rd(8'h70, v); check("R11 mode readback", v, 1);
    wr(8'h70, 0); idle(4);

    finish_run();
  end
endmodule